// File: doc/BRIEF.md
# Narrow Store Lane Replicator

This block sits between a processor's uncached store path and a memory bus that accepts only whole 64-bit writes and has no per-byte enables. Each incoming request carries a read/write flag, an address, a size code and up to 64 bits of data. For a store narrower than a word, the block builds a full 8-byte write. It places the byte or halfword in its 32-bit half according to the two low address bits and copies that half into the other half. Every remaining byte lane is zero, so a narrow store deliberately overwrites its neighbours.

Word stores land only in the half selected by address bit 2. A two-bit half strobe tells the memory side which halves to update, so the other half survives through a read-modify-write. Doubleword stores and all reads go through untouched. A single register stage with valid/ready handshakes on both sides holds at most one request at a time.

Top module: `store_lane_fanout`

## Requirements
- R1: While `rst_n` is low, and for the first clock edge after it is released, `out_valid` and `in_ready` are 0. From the second edge after release, with nothing held, `in_ready` is 1.
- R2: A request taken when `in_valid` and `in_ready` are both high appears on the outputs with `out_valid` high after exactly one clock edge. While `out_valid` is high, `in_ready` is 0. While `out_valid` is high and `out_ready` is low, every output stays unchanged and new requests are not taken.
- R3: For a store (`in_write`=1), `out_addr` equals `in_addr` with bits 2:0 cleared.
- R4: Size 0 (byte) store with k = `in_addr[1:0]`: byte `in_data[7:0]` appears in lanes k and k+4, all other lanes are 0, and `out_half_en`=2'b11. Lane j occupies `out_data[63-8j -: 8]`, so lane 0 is the most significant byte.
- R5: Size 1 (halfword) store with k = 0..2: the high byte `in_data[15:8]` goes to lanes k and k+4, the low byte `in_data[7:0]` goes to lanes k+1 and k+5, all other lanes are 0, and `out_half_en`=2'b11.
- R6: Halfword store with k = 3 wraps inside each half: the high byte goes to lanes 3 and 7, the low byte goes to lanes 0 and 4, all other lanes are 0.
- R7: Size 2 (word) store: `in_data[31:0]` goes to `out_data[63:32]` with `out_half_en`=2'b10 when `in_addr[2]`=0, or to `out_data[31:0]` with `out_half_en`=2'b01 when `in_addr[2]`=1. The other half is 0, and `in_addr[1:0]` has no effect.
- R8: Size 3 (doubleword) store: `out_data` equals `in_data` and `out_half_en`=2'b11.
- R9: A read (`in_write`=0) passes with `out_write`=0, `out_addr`=`in_addr` (unaligned bits kept), `out_size`=`in_size`, `out_data`=`in_data` and `out_half_en`=2'b00.
- R10: For byte, halfword and word stores, `in_data` bits above the size's width have no effect on `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_write | input | 1 | 1 = store, 0 = read |
| in_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| in_addr | input | ADDR_W | Byte address |
| in_data | input | 64 | Store data, right-justified |
| out_valid | output | 1 | Bus request present |
| out_ready | input | 1 | Bus takes the request |
| out_write | output | 1 | Copy of the store flag |
| out_size | output | 2 | Copy of the size code |
| out_addr | output | ADDR_W | Aligned for stores, unchanged for reads |
| out_data | output | 64 | Formatted 64-bit bus data |
| out_half_en | output | 2 | Half strobe: bit 1 for bits 63:32, bit 0 for bits 31:0 |

## Verification
The checker assumes the upstream side holds a request steady until it is taken, and that the bus side does not act on the outputs while `out_valid` is low. The bench meets both conditions. It changes inputs only on the falling edge, and it takes a request down only after the rising edge that accepted it. During a backpressure episode the bench deliberately presents a different request while the stage is full. This shows that a well-behaved producer that offers another request early still cannot disturb the held one.

// File: rtl/slf_pkg.sv
package slf_pkg;
  localparam int unsigned BUS_W      = 64;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned HALF_W     = BUS_W / 2;
  localparam int unsigned HALVES     = BUS_W / HALF_W;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } slf_size_e;
endpackage

// File: rtl/slf_rst_sync.sv
module slf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign run = s2_q;
endmodule

// File: rtl/slf_lane_map.sv
module slf_lane_map
  import slf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  data,
  output logic [ADDR_W-1:0] map_addr,
  output logic [BUS_W-1:0]  map_data,
  output logic [HALVES-1:0] map_half_en
);
  localparam int unsigned OFS_W = $clog2(HALF_W / LANE_W);
  localparam int unsigned ALN_W = $clog2(BUS_W / LANE_W);

  logic [HALF_W-1:0]   seed;
  logic [2*HALF_W-1:0] dbl;
  logic [HALF_W-1:0]   narrow_half;
  logic [OFS_W-1:0]    ofs;
  logic                upper_sel;

  assign ofs       = addr[OFS_W-1:0];
  assign upper_sel = ~addr[OFS_W];

  // Left-justify the narrow item, then rotate right by the lane offset.
  always_comb begin
    seed = '0;
    case (slf_size_e'(size))
      SZ_BYTE: seed = {data[LANE_W-1:0], {(HALF_W-LANE_W){1'b0}}};
      SZ_HALF: seed = {data[2*LANE_W-1:0], {(HALF_W-2*LANE_W){1'b0}}};
      default: seed = '0;
    endcase
    dbl         = {seed, seed} >> (LANE_W * ofs);
    narrow_half = dbl[HALF_W-1:0];
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    logic hit;
    logic own;
    assign own = ((g == HALVES - 1) == upper_sel);
    assign hit = write && ((slf_size_e'(size) == SZ_WORD) ? own : 1'b1);
    assign map_half_en[g] = hit;
    assign map_data[g*HALF_W +: HALF_W] =
      !write                            ? data[g*HALF_W +: HALF_W] :
      (slf_size_e'(size) == SZ_DWORD)   ? data[g*HALF_W +: HALF_W] :
      (slf_size_e'(size) == SZ_WORD)    ? (hit ? data[HALF_W-1:0] : '0) :
                                          narrow_half;
  end

  assign map_addr = write ? {addr[ADDR_W-1:ALN_W], {ALN_W{1'b0}}} : addr;
endmodule

// File: rtl/slf_hold_reg.sv
module slf_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  logic         full_q, full_d;
  logic         load_en;
  logic [W-1:0] pay_q;

  assign in_ready = run & ~full_q;
  assign load_en  = in_valid & in_ready;

  always_comb begin
    full_d = full_q;
    if (load_en)                  full_d = 1'b1;
    else if (full_q && out_ready) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) pay_q <= in_payload;
  end

  assign out_valid   = full_q;
  assign out_payload = pay_q;
endmodule

// File: rtl/store_lane_fanout.sv
module store_lane_fanout
  import slf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_write,
  input  logic [1:0]        in_size,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BUS_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_write,
  output logic [1:0]        out_size,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BUS_W-1:0]  out_data,
  output logic [HALVES-1:0] out_half_en
);
  typedef struct packed {
    logic              write;
    logic [1:0]        size;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  data;
    logic [HALVES-1:0] half_en;
  } slf_req_t;

  localparam int unsigned REQ_W = $bits(slf_req_t);

  logic     run;
  slf_req_t req_in, req_out;

  slf_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  assign req_in.write = in_write;
  assign req_in.size  = in_size;

  slf_lane_map #(.ADDR_W(ADDR_W)) u_map (
    .write       (in_write),
    .size        (in_size),
    .addr        (in_addr),
    .data        (in_data),
    .map_addr    (req_in.addr),
    .map_data    (req_in.data),
    .map_half_en (req_in.half_en)
  );

  slf_hold_reg #(.W(REQ_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_payload  (req_in),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_payload (req_out)
  );

  assign out_write   = req_out.write;
  assign out_size    = req_out.size;
  assign out_addr    = req_out.addr;
  assign out_data    = req_out.data;
  assign out_half_en = req_out.half_en;
endmodule

// File: rtl/slf_checker.sv
module slf_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_write,
  input logic [1:0]        out_size,
  input logic [ADDR_W-1:0] out_addr,
  input logic [63:0]       out_data,
  input logic [1:0]        out_half_en
);
  assert_accept_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_one_in_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr)
      && $stable(out_half_en) && $stable(out_size) && $stable(out_write));

  assert_store_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write |-> out_addr[2:0] == 3'b000);

  assert_byte_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write && out_size == 2'd0 |->
      out_data[63:32] == out_data[31:0] && out_half_en == 2'b11
      && $countones(out_data[31:0]) <= 8);

  assert_half_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write && out_size == 2'd1 |->
      out_data[63:32] == out_data[31:0] && out_half_en == 2'b11);

  assert_word_one_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write && out_size == 2'd2 |-> $countones(out_half_en) == 1);

  assert_dword_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_write && out_size == 2'd3 |-> out_half_en == 2'b11);

  assert_read_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_write |-> out_half_en == 2'b00);
endmodule

bind store_lane_fanout slf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_write   (out_write),
  .out_size    (out_size),
  .out_addr    (out_addr),
  .out_data    (out_data),
  .out_half_en (out_half_en)
);

// File: tb/sim_store_lane_fanout.sv
`timescale 1ns/1ps
module sim_store_lane_fanout;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          in_valid, in_ready, in_write;
  logic [1:0]    in_size;
  logic [AW-1:0] in_addr;
  logic [63:0]   in_data;
  logic          out_valid, out_ready, out_write;
  logic [1:0]    out_size;
  logic [AW-1:0] out_addr;
  logic [63:0]   out_data;
  logic [1:0]    out_half_en;

  int checks = 0;
  int errors = 0;

  store_lane_fanout #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_write(in_write),
    .in_size(in_size), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_write(out_write),
    .out_size(out_size), .out_addr(out_addr), .out_data(out_data),
    .out_half_en(out_half_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // Lane-by-lane model: lane j lives at bits 63-8j .. 56-8j.
  function automatic logic [63:0] model_data(input logic wr, input logic [1:0] sz,
                                             input logic [AW-1:0] a, input logic [63:0] d);
    logic [63:0] r;
    int k;
    r = '0;
    k = int'(a[1:0]);
    if (!wr || sz == 2'd3) return d;
    for (int j = 0; j < 8; j++) begin
      logic [7:0] v;
      v = 8'h00;
      case (sz)
        2'd0: if (j % 4 == k) v = d[7:0];
        2'd1: begin
          if (j % 4 == k) v = d[15:8];
          else if (j % 4 == (k + 1) % 4) v = d[7:0];
        end
        default: if ((j / 4) == int'(a[2])) v = d[31 - 8*(j%4) -: 8];
      endcase
      r[63 - 8*j -: 8] = v;
    end
    return r;
  endfunction

  function automatic string tag_for(input logic wr, input logic [1:0] sz,
                                    input logic [AW-1:0] a);
    if (!wr) return "R9";
    case (sz)
      2'd0:    return "R4";
      2'd1:    return (a[1:0] == 2'd3) ? "R6" : "R5";
      2'd2:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic send(input logic wr, input logic [1:0] sz,
                      input logic [AW-1:0] a, input logic [63:0] d);
    logic [1:0] hen;
    string tg;
    tg = tag_for(wr, sz, a);
    @(negedge clk);
    in_valid = 1'b1; in_write = wr; in_size = sz; in_addr = a; in_data = d;
    out_ready = 1'b1;
    check("R2", "in_ready before accept", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "out_valid after accept", {63'd0, out_valid}, 64'd1);
    if (!wr) hen = 2'b00;
    else if (sz == 2'd2) hen = a[2] ? 2'b01 : 2'b10;
    else hen = 2'b11;
    check(wr ? "R3" : "R9", "addr", 64'(out_addr),
          wr ? 64'({a[AW-1:3], 3'b000}) : 64'(a));
    check(tg, "data (R10 upper bits set)", out_data, model_data(wr, sz, a, d));
    check(tg, "half_en", 64'(out_half_en), 64'(hen));
    check("R9", "write/size passthrough", {61'd0, out_write, out_size}, {61'd0, wr, sz});
    @(negedge clk);
    check("R2", "drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    logic [63:0] pats [3];
    logic [63:0] held;
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hFEDC_BA98_7654_3210;
    pats[2] = 64'hA5C3_5A3C_9669_F00F;
    rst_n = 1'b0; in_valid = 1'b0; in_write = 1'b0; in_size = 2'd0;
    in_addr = '0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1", "in_ready in reset", {63'd0, in_ready}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "in_ready one edge after release", {63'd0, in_ready}, 64'd0);
    @(negedge clk);
    check("R1", "in_ready two edges after release", {63'd0, in_ready}, 64'd1);
    check("R1", "out_valid idle", {63'd0, out_valid}, 64'd0);

    for (int wr = 0; wr < 2; wr++)
      for (int sz = 0; sz < 4; sz++)
        for (int ofs = 0; ofs < 8; ofs++)
          for (int p = 0; p < 3; p++)
            send(wr[0], sz[1:0], 32'h1234_5A00 + 32'(ofs), pats[p]);

    // R2 backpressure: hold a byte store while a different request is offered.
    @(negedge clk);
    in_valid = 1'b1; in_write = 1'b1; in_size = 2'd0;
    in_addr = 32'h0000_0A02; in_data = 64'h0000_0000_0000_00AA;
    out_ready = 1'b0;
    @(negedge clk);
    held = out_data;
    check("R2", "hold data", held, 64'h0000_AA00_0000_AA00);
    in_write = 1'b0; in_size = 2'd3; in_addr = 32'h0000_0B05; in_data = 64'h1111_2222_3333_4444;
    repeat (3) begin
      @(negedge clk);
      check("R2", "in_ready low while full", {63'd0, in_ready}, 64'd0);
      check("R2", "held data stable", out_data, held);
      check("R2", "held addr stable", 64'(out_addr), 64'h0000_0A00);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R2", "released", {63'd0, out_valid}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule